// File: doc/BRIEF.md
# Burst Address Sequence Generator

This block produces the address presented to a synchronous burst memory. A full address is captured from the external address bus when a load is requested through either of two start strobes: one driven by a processor and one driven by a memory controller. After the capture, the two lowest address bits are stepped internally on every clock where the advance input is high. The upper bits stay frozen until the next load.

A static order input picks how the low bits walk. In linear order the start offset is incremented modulo four. In interleaved order the start offset is XORed with the beat number. Either way the sequence comes back to the start offset after four advances. The processor strobe only takes effect while the chip enable is high. The controller strobe loads whatever the chip enable is. Loads may be issued on every cycle, so single accesses need no burst at all.

The output is driven combinationally from internal registers. A load or an advance sampled at a rising edge is therefore visible on `addr_out` just after that edge.

Top module: `burst_addr_gen`

## Requirements
- R1: A synchronous reset, `rst` high at a rising edge, sets `addr_out` to zero and leaves no burst active. Until the first load, `adv` has no effect and `addr_out` stays zero.
- R2: `ctl_start` high at a rising edge loads `addr_in` into `addr_out` after that edge, whatever the value of `chip_en`.
- R3: `cpu_start` high at a rising edge loads `addr_in` only when `chip_en` is high. With `chip_en` low, the edge behaves as if no strobe was given.
- R4: With a burst active and no load, a rising edge with `adv` high steps the low two bits once. With `adv` low, `addr_out` holds.
- R5: With `interleave` = 0 (linear), after n advances since the load the low two bits equal (start + n) mod 4.
- R6: With `interleave` = 1, after n advances since the load the low two bits equal start XOR (n mod 4).
- R7: After four advances the low two bits equal the start offset again, for every start offset in both orders.
- R8: Bits `addr_out[ADDR_W-1:2]` change only on a load.
- R9: When a load and `adv` are both high at the same edge, the load wins. `addr_out` becomes `addr_in` with no step applied.
- R10: Loads on consecutive edges each present their own `addr_in` on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | ADDR_W | External address captured on a load |
| cpu_start | input | 1 | Processor start strobe, active high, gated by `chip_en` |
| ctl_start | input | 1 | Controller start strobe, active high, not gated |
| adv | input | 1 | Advance the burst by one beat |
| interleave | input | 1 | Order select: 0 linear, 1 interleaved |
| chip_en | input | 1 | Chip enable, active high |
| addr_out | output | ADDR_W | Current internal address |

## Verification
On every cycle the assertions check four things. The upper bits hold when no load occurs. An unrequested cycle holds the whole address. A controller load captures the input bus even with the chip disabled. A linear advance adds exactly one to the low bits. Only the bench's scenarios show the full five-beat sequences for all four start offsets in both orders, including the return to the start offset. The same holds for the load-over-advance priority, consecutive loads, and the masking of a processor start with the chip disabled.

// File: rtl/burst_addr_gen.sv
module burst_addr_gen #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              cpu_start,
  input  logic              ctl_start,
  input  logic              adv,
  input  logic              interleave,
  input  logic              chip_en,
  output logic [ADDR_W-1:0] addr_out
);
  localparam int CNT_W = 2;

  logic [ADDR_W-1:0] base_q;
  logic [CNT_W-1:0]  beat_q;
  logic              active_q;
  logic              load;
  logic              step;
  logic [CNT_W-1:0]  low;

  assign load = ctl_start | (cpu_start & chip_en);
  assign step = ~load & adv & active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      base_q   <= '0;
      beat_q   <= '0;
      active_q <= 1'b0;
    end else if (load) begin
      base_q   <= addr_in;
      beat_q   <= '0;
      active_q <= 1'b1;
    end else if (step) begin
      beat_q   <= beat_q + 1'b1;
    end
  end

  assign low = interleave ? (base_q[CNT_W-1:0] ^ beat_q)
                          : (base_q[CNT_W-1:0] + beat_q);
  assign addr_out = {base_q[ADDR_W-1:CNT_W], low};

  // R8
  upper_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !(ctl_start || (cpu_start && chip_en)) |=> $stable(addr_out[ADDR_W-1:CNT_W]));

  // R4
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !ctl_start && !(cpu_start && chip_en) && !adv |=> $stable(addr_out));

  // R2
  ctl_load_chk: assert property (@(posedge clk) disable iff (rst)
    ctl_start |=> addr_out == $past(addr_in));

  // R5
  linear_step_chk: assert property (@(posedge clk) disable iff (rst)
    active_q && !ctl_start && !(cpu_start && chip_en) && adv && !interleave
    |=> addr_out[CNT_W-1:0] == $past(addr_out[CNT_W-1:0]) + 2'd1);
endmodule

// File: tb/tb_burst_addr_gen.sv
module tb_burst_addr_gen;
  localparam int CLK_PERIOD = 10;
  localparam int W = 16;

  // index = {interleave, start[1:0]}; beat k at [2k +: 2]
  localparam logic [9:0] SEQ [8] = '{
    {2'd0, 2'd3, 2'd2, 2'd1, 2'd0},
    {2'd1, 2'd0, 2'd3, 2'd2, 2'd1},
    {2'd2, 2'd1, 2'd0, 2'd3, 2'd2},
    {2'd3, 2'd2, 2'd1, 2'd0, 2'd3},
    {2'd0, 2'd3, 2'd2, 2'd1, 2'd0},
    {2'd1, 2'd2, 2'd3, 2'd0, 2'd1},
    {2'd2, 2'd1, 2'd0, 2'd3, 2'd2},
    {2'd3, 2'd0, 2'd1, 2'd2, 2'd3}
  };

  logic clk = 0, rst = 1;
  logic [W-1:0] addr_in = '0;
  logic cpu_start = 0, ctl_start = 0, adv = 0, interleave = 0, chip_en = 0;
  logic [W-1:0] addr_out;
  int tests = 0, fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  burst_addr_gen #(.ADDR_W(W)) dut (
    .clk(clk), .rst(rst), .addr_in(addr_in), .cpu_start(cpu_start),
    .ctl_start(ctl_start), .adv(adv), .interleave(interleave),
    .chip_en(chip_en), .addr_out(addr_out));

  task automatic cyc(input logic r, input logic cs, input logic ks,
                     input logic a, input logic ce, input logic [W-1:0] ad);
    @(negedge clk);
    rst = r; cpu_start = cs; ctl_start = ks; adv = a; chip_en = ce; addr_in = ad;
    @(posedge clk);
    #2;
  endtask

  task automatic chk(input string req, input logic [W-1:0] exp);
    tests++;
    if (addr_out !== exp) begin
      fails++;
      $display("FAIL %s: addr_out=%h expected=%h", req, addr_out, exp);
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    cyc(1, 0, 0, 0, 0, 16'hFFFF);
    chk("R1 reset", 16'h0000);
    cyc(0, 0, 0, 1, 1, 16'h1234);
    chk("R1 adv before load", 16'h0000);

    for (int i = 0; i < 8; i++) begin
      logic [W-1:0] a;
      a = {14'h0A5 + 14'(i * 7), 2'(i)};
      interleave = i[2];
      cyc(0, 1, 0, 0, 1, a);
      chk("R5_R6 beat0", a);
      for (int k = 1; k <= 4; k++) begin
        cyc(0, 0, 0, 1, 1, 16'h0000);
        chk(k == 4 ? "R7 wrap" : (i[2] ? "R6 interleaved" : "R5 linear"),
            {a[W-1:2], SEQ[i][2*k +: 2]});
      end
    end

    interleave = 0;
    cyc(0, 1, 0, 0, 1, 16'h4001);
    cyc(0, 0, 0, 1, 1, 16'h0000);
    cyc(0, 0, 0, 0, 1, 16'hFFFF);
    chk("R4 hold without adv", 16'h4002);
    cyc(0, 0, 0, 0, 1, 16'hFFFF);
    chk("R8 upper stable", 16'h4002);

    cyc(0, 0, 1, 0, 0, 16'h7E02);
    chk("R2 ctl load with chip disabled", 16'h7E02);
    cyc(0, 1, 0, 0, 0, 16'h1111);
    chk("R3 cpu start masked", 16'h7E02);
    cyc(0, 1, 0, 0, 1, 16'h2223);
    chk("R3 cpu start enabled", 16'h2223);

    cyc(0, 0, 0, 1, 1, 16'h0000);
    chk("R4 step", 16'h2220);
    cyc(0, 1, 0, 1, 1, 16'h5552);
    chk("R9 load beats adv", 16'h5552);

    cyc(0, 0, 1, 0, 1, 16'hA001);
    chk("R10 load 1", 16'hA001);
    cyc(0, 1, 0, 0, 1, 16'hB002);
    chk("R10 load 2", 16'hB002);
    cyc(0, 0, 1, 1, 0, 16'hC003);
    chk("R10 load 3", 16'hC003);

    cyc(1, 0, 0, 1, 1, 16'h0000);
    chk("R1 mid-burst reset", 16'h0000);
    cyc(0, 0, 0, 1, 1, 16'h0000);
    chk("R1 adv after reset", 16'h0000);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule